// File: doc/BRIEF.md
# USB Low/Full-Speed Bit-Level Receiver

This block turns a USB differential pair, sampled directly by the system clock, into a stream of bytes. The two pins pass through a synchronizer and are classified as J, K, SE0 or SE1. One input chooses low or full speed, and the choice swaps which pin carries J. Bit timing comes from a phase accumulator. Every change of line state reloads it to the middle of its range, so the sampling point stays centred even when the system clock is not an exact multiple of the bit rate.

At each sampling point the receiver first hunts for the sync pattern. Once sync is found it decodes NRZI, drops stuffed bits and packs the data least significant bit first. Each completed byte is reported with a one-cycle strobe. Two SE0 bit times close a packet. If a seventh consecutive one arrives, the packet is abandoned and an error pulse is raised. CRC checking, PID decoding and everything above the byte level are left to software.

Top module: `fs_line_receiver`

## Requirements
- R1: With `lo_speed`=0, line_p=1 and line_n=0 is J and line_p=0 and line_n=1 is K. With `lo_speed`=1 the two pins swap roles. Both pins low is SE0.
- R2: Every change of the classified line state reloads the phase accumulator to half scale. A bit is sampled each time the accumulator, advanced by `phase_step` per clock, wraps. Reception therefore tolerates a step that is about 5% away from the nominal rate.
- R3: NRZI decoding: a sampled symbol equal to the previous one is a 1, and a changed symbol is a 0.
- R4: While hunting, the last eight sampled symbols K J K J K J K K (oldest first) start a packet. This raises `pkt_start` for exactly one cycle.
- R5: Data bits are packed least significant bit first. After every eighth data bit, `byte_valid` pulses for one cycle with the byte on `byte_data`.
- R6: After six consecutive 1 bits, the next bit is discarded. The final K of sync counts as the first of these ones.
- R7: If the bit after six consecutive ones is a 1, `stuff_err` pulses for one cycle. The packet is abandoned, with no further bytes and no `pkt_end`.
- R8: Two consecutive SE0 samples inside a packet pulse `pkt_end` once. Any partly assembled byte is dropped.
- R9: During and right after reset, `byte_valid`, `pkt_start`, `pkt_end` and `stuff_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also used to sample the pins |
| rst_n | input | 1 | Active-low synchronous reset |
| lo_speed | input | 1 | 1 selects low-speed pin roles |
| line_p | input | 1 | Positive line of the pair, asynchronous |
| line_n | input | 1 | Negative line of the pair, asynchronous |
| phase_step | input | NCO_W | Accumulator increment per clock (2^NCO_W / clocks per bit) |
| byte_valid | output | 1 | One-cycle strobe for a completed byte |
| byte_data | output | 8 | Received byte, valid with byte_valid |
| pkt_start | output | 1 | One-cycle pulse when sync is recognised |
| pkt_end | output | 1 | One-cycle pulse at end-of-packet |
| stuff_err | output | 1 | One-cycle pulse when a seventh consecutive one is seen |

## Verification
A wrong internal state shows up at the ports quickly:
- A mis-kept ones count or NRZI reference corrupts a byte within that same byte, which a comparison against the sent data catches.
- A wrong stuff count makes the assembly lose bit alignment, so every later byte in the packet differs. It also shifts the byte count, or raises `stuff_err` where none is expected.
- A phase that does not reload on edges drifts under the 5% rate offset. Within about ten bits it samples twice or skips a bit, and the packet fails.
- A decoder that fails to return to hunting shows as a missing `pkt_start` on the very next packet.

// File: rtl/fsrx_pkg.sv
package fsrx_pkg;

  typedef enum logic [1:0] {
    LN_SE0 = 2'b00,
    LN_J   = 2'b01,
    LN_K   = 2'b10,
    LN_SE1 = 2'b11
  } line_t;

  typedef enum logic [1:0] {
    ST_HUNT = 2'b00,
    ST_DATA = 2'b01,
    ST_EOP1 = 2'b10
  } rx_state_t;

  // K=1, J=0; oldest symbol in bit 7
  localparam logic [7:0] SYNC_SYMBOLS = 8'b1010_1011;
  localparam int unsigned STUFF_LIMIT = 6;

  // After optional swap, J is plus-high/minus-low
  function automatic line_t classify(input logic plus, input logic minus,
                                     input logic swap);
    logic p, m;
    p = swap ? minus : plus;
    m = swap ? plus : minus;
    return line_t'({m, p});
  endfunction

  function automatic logic nrzi_bit(input line_t prev, input line_t cur);
    return (prev == cur);
  endfunction

  function automatic logic [2:0] next_ones(input logic [2:0] ones, input logic b);
    return b ? ones + 3'd1 : 3'd0;
  endfunction

endpackage

// File: rtl/fsrx_line_sampler.sv
module fsrx_line_sampler
  import fsrx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  swap,
  input  logic  pin_p,
  input  logic  pin_n,
  output line_t line_now,
  output logic  line_edge
);
  logic [SYNC_STAGES-1:0] sp;
  logic [SYNC_STAGES-1:0] sn;
  line_t prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          sp <= 1'b0;
          sn <= 1'b0;
        end else begin
          sp <= pin_p;
          sn <= pin_n;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          sp <= '0;
          sn <= '0;
        end else begin
          sp <= {sp[SYNC_STAGES-2:0], pin_p};
          sn <= {sn[SYNC_STAGES-2:0], pin_n};
        end
      end
    end
  endgenerate

  assign line_now  = classify(sp[SYNC_STAGES-1], sn[SYNC_STAGES-1], swap);
  assign line_edge = (line_now != prev_q);

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= LN_SE0;
    else        prev_q <= line_now;
  end
endmodule

// File: rtl/fsrx_bit_nco.sv
module fsrx_bit_nco #(
  parameter int NCO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             relock,
  input  logic [NCO_W-1:0] step,
  output logic             strobe,
  output logic [NCO_W-1:0] phase
);
  localparam logic [NCO_W-1:0] HALF = NCO_W'(1) << (NCO_W - 1);

  logic [NCO_W:0] sum;

  assign sum    = {1'b0, phase} + {1'b0, step};
  assign strobe = !relock && sum[NCO_W];

  always_ff @(posedge clk) begin
    if (!rst_n)      phase <= HALF;
    else if (relock) phase <= HALF;
    else             phase <= sum[NCO_W-1:0];
  end
endmodule

// File: rtl/fsrx_decoder.sv
module fsrx_decoder
  import fsrx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample,
  input  line_t      line,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic       pkt_start,
  output logic       pkt_end,
  output logic       stuff_err,
  output logic       in_packet,
  output logic [2:0] ones_count
);
  rx_state_t  state;
  logic [7:0] hist;
  logic [7:0] hist_next;
  logic [7:0] shreg;
  logic [2:0] bitc;
  line_t      prev_sym;
  logic       is_kj;
  logic       bit_now;

  assign is_kj      = (line == LN_J) || (line == LN_K);
  assign hist_next  = {hist[6:0], line == LN_K};
  assign bit_now    = nrzi_bit(prev_sym, line);
  assign in_packet  = (state != ST_HUNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_HUNT;
      hist       <= '0;
      shreg      <= '0;
      bitc       <= '0;
      ones_count <= '0;
      prev_sym   <= LN_J;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      pkt_start  <= 1'b0;
      pkt_end    <= 1'b0;
      stuff_err  <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      pkt_start  <= 1'b0;
      pkt_end    <= 1'b0;
      stuff_err  <= 1'b0;
      if (sample) begin
        unique case (state)
          ST_HUNT: begin
            if (is_kj) begin
              hist <= hist_next;
              if (hist_next == SYNC_SYMBOLS) begin
                state      <= ST_DATA;
                pkt_start  <= 1'b1;
                ones_count <= 3'd1;
                bitc       <= '0;
                prev_sym   <= line;
              end
            end else begin
              hist <= '0;
            end
          end
          ST_DATA: begin
            if (line == LN_SE0) begin
              state <= ST_EOP1;
            end else if (!is_kj) begin
              state <= ST_HUNT;
              hist  <= '0;
            end else begin
              prev_sym <= line;
              if (ones_count == 3'(STUFF_LIMIT)) begin
                if (bit_now) begin
                  stuff_err <= 1'b1;
                  state     <= ST_HUNT;
                  hist      <= '0;
                end else begin
                  ones_count <= '0;
                end
              end else begin
                ones_count <= next_ones(ones_count, bit_now);
                shreg      <= {bit_now, shreg[7:1]};
                bitc       <= bitc + 3'd1;
                if (bitc == 3'd7) begin
                  byte_valid <= 1'b1;
                  byte_data  <= {bit_now, shreg[7:1]};
                end
              end
            end
          end
          default: begin
            if (line == LN_SE0) pkt_end <= 1'b1;
            state <= ST_HUNT;
            hist  <= '0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/fs_line_receiver.sv
module fs_line_receiver
  import fsrx_pkg::*;
#(
  parameter int NCO_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lo_speed,
  input  logic             line_p,
  input  logic             line_n,
  input  logic [NCO_W-1:0] phase_step,
  output logic             byte_valid,
  output logic [7:0]       byte_data,
  output logic             pkt_start,
  output logic             pkt_end,
  output logic             stuff_err
);
  line_t            line_now;
  logic             line_edge;
  logic             sample;
  logic [NCO_W-1:0] nco_phase;
  logic             in_packet;
  logic [2:0]       ones_count;

  fsrx_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
    .clk       (clk),
    .rst_n     (rst_n),
    .swap      (lo_speed),
    .pin_p     (line_p),
    .pin_n     (line_n),
    .line_now  (line_now),
    .line_edge (line_edge)
  );

  fsrx_bit_nco #(.NCO_W(NCO_W)) u_nco (
    .clk    (clk),
    .rst_n  (rst_n),
    .relock (line_edge),
    .step   (phase_step),
    .strobe (sample),
    .phase  (nco_phase)
  );

  fsrx_decoder u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample     (sample),
    .line       (line_now),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .pkt_start  (pkt_start),
    .pkt_end    (pkt_end),
    .stuff_err  (stuff_err),
    .in_packet  (in_packet),
    .ones_count (ones_count)
  );
endmodule

// File: rtl/fsrx_checker.sv
module fsrx_checker #(
  parameter int NCO_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             byte_valid,
  input logic             pkt_start,
  input logic             pkt_end,
  input logic             stuff_err,
  input logic             in_packet,
  input logic [2:0]       ones_count,
  input logic             line_edge,
  input logic [NCO_W-1:0] nco_phase
);
  localparam logic [NCO_W-1:0] HALF = NCO_W'(1) << (NCO_W - 1);

  a_r2_relock_half: assert property (@(posedge clk) disable iff (!rst_n)
    line_edge |=> nco_phase == HALF);

  a_r4_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |-> in_packet);

  a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |=> !pkt_start);

  a_r5_byte_inside: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> in_packet);

  a_r5_byte_single: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  a_r7_err_after_six: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_err |-> (!in_packet && $past(ones_count) == 3'd6));

  a_r8_end_closes: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |-> !in_packet);

  a_r9_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({byte_valid, pkt_start, pkt_end, stuff_err}));
endmodule

bind fs_line_receiver fsrx_checker #(.NCO_W(NCO_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .byte_valid (byte_valid),
  .pkt_start  (pkt_start),
  .pkt_end    (pkt_end),
  .stuff_err  (stuff_err),
  .in_packet  (in_packet),
  .ones_count (ones_count),
  .line_edge  (line_edge),
  .nco_phase  (nco_phase)
);

// File: tb/sim_fs_line_receiver.sv
module sim_fs_line_receiver;
  localparam int W   = 16;
  localparam int PER = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         lo_speed = 1'b0;
  logic         line_p = 1'b1;
  logic         line_n = 1'b0;
  logic [W-1:0] phase_step = 16'd8192;
  logic         byte_valid;
  logic [7:0]   byte_data;
  logic         pkt_start, pkt_end, stuff_err;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  logic [7:0] pk [0:15];
  logic [7:0] rx [0:31];
  int rx_n = 0, n_start = 0, n_end = 0, n_err = 0;
  int cur;   // 1 = J, 2 = K, 0 = SE0
  int ones;

  always #2 clk = ~clk;

  fs_line_receiver #(.NCO_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .lo_speed(lo_speed),
    .line_p(line_p), .line_n(line_n), .phase_step(phase_step),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .pkt_start(pkt_start), .pkt_end(pkt_end), .stuff_err(stuff_err)
  );

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (rst_n) begin
      if (byte_valid) begin
        if (rx_n < 32) rx[rx_n] = byte_data;
        rx_n = rx_n + 1;
      end
      if (pkt_start) n_start = n_start + 1;
      if (pkt_end)   n_end   = n_end + 1;
      if (stuff_err) n_err   = n_err + 1;
    end
    if (cycles > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R1 pin mapping, restated for the bench
  task automatic put(input int s);
    logic jp;
    jp = lo_speed ? 1'b0 : 1'b1;
    case (s)
      0: begin line_p = 1'b0; line_n = 1'b0; end
      1: begin line_p = jp;   line_n = ~jp;  end
      default: begin line_p = ~jp; line_n = jp; end
    endcase
    repeat (PER) @(negedge clk);
  endtask

  // R3 NRZI: 0 toggles, 1 holds
  task automatic emit(input logic b);
    if (!b) cur = (cur == 1) ? 2 : 1;
    put(cur);
  endtask

  task automatic send(input int n, input bit nostuff, input int extra);
    for (int i = 0; i < 4; i++) put(1);
    put(2); put(1); put(2); put(1); put(2); put(1); put(2); put(2);
    cur = 2;
    ones = 1;  // R6 sync's last K counts
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++) begin
        emit(pk[i][k]);
        ones = pk[i][k] ? ones + 1 : 0;
        if (ones == 6 && !nostuff) begin
          emit(1'b0);
          ones = 0;
        end
      end
    for (int i = 0; i < extra; i++) emit(1'b0);
    put(0); put(0);
    for (int i = 0; i < 4; i++) put(1);
  endtask

  task automatic clear_counts();
    rx_n = 0; n_start = 0; n_end = 0; n_err = 0;
  endtask

  task automatic run_pkt(input string req, input int n, input int extra);
    clear_counts();
    send(n, 1'b0, extra);
    check({req, " start"}, n_start, 1);
    check({req, " end R8"}, n_end, 1);
    check({req, " err"}, n_err, 0);
    check({req, " count R5"}, rx_n, n);
    for (int i = 0; i < n && i < 32; i++)
      if (rx[i] != pk[i]) check({req, " byte R5"}, rx[i], pk[i]);
      else total = total + 1;
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset", {byte_valid, pkt_start, pkt_end, stuff_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after reset", {byte_valid, pkt_start, pkt_end, stuff_err}, 0);
    repeat (20) @(negedge clk);

    // R3/R5 directed patterns
    pk[0] = 8'hA5; pk[1] = 8'h00; pk[2] = 8'h01;
    run_pkt("R3 R4 directed", 3, 0);

    // R6 stuffing: runs of ones
    pk[0] = 8'hFF; pk[1] = 8'hFF; pk[2] = 8'h7E; pk[3] = 8'h3F;
    run_pkt("R6 stuff", 4, 0);

    // R8 partial byte dropped
    pk[0] = 8'h5C; pk[1] = 8'hC3;
    run_pkt("R8 partial", 2, 5);

    // random packets
    for (int p = 0; p < 12; p++) begin
      int n;
      n = 1 + int'($urandom_range(0, 15));
      for (int i = 0; i < n; i++) pk[i] = 8'($urandom);
      if (p % 3 == 0) pk[0] = 8'hFF;
      run_pkt("R5 random", n, 0);
    end

    // R1 low speed pin roles
    lo_speed = 1'b1;
    line_p = 1'b0; line_n = 1'b1;
    repeat (40) @(negedge clk);
    pk[0] = 8'h96; pk[1] = 8'hF0; pk[2] = 8'h3E;
    run_pkt("R1 low speed", 3, 0);
    lo_speed = 1'b0;
    line_p = 1'b1; line_n = 1'b0;
    repeat (40) @(negedge clk);

    // R2 step about 5% fast, relock keeps sampling centred
    phase_step = 16'd8600;
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < 6; i++) pk[i] = 8'($urandom);
      pk[2] = 8'hFF;
      run_pkt("R2 fast step", 6, 0);
    end
    phase_step = 16'd8192;

    // R7 missing stuff bit
    pk[0] = 8'hFF;
    clear_counts();
    send(1, 1'b1, 0);
    check("R7 err", n_err, 1);
    check("R7 no bytes", rx_n, 0);
    check("R7 no end", n_end, 0);

    // recovery after error
    pk[0] = 8'h42; pk[1] = 8'h81;
    run_pkt("R4 after error", 2, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule